// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Level-One Data Cache

This block is a two-way set-associative data cache that sits between a load/store unit and a line-granular memory port. A request carries a virtual address. On the cycle the request is accepted, the set is chosen from untranslated address bits and both ways' tags and lines are read into registers. In the next cycle the translation unit returns the physical page number for the request's virtual page, and each stored tag is compared with it. The set index lies wholly inside the page offset. The two reads can therefore overlap, and two virtual names for one physical word always select the same set.

The default geometry uses 16 KB pages and 32-byte lines, with nine index bits (512 sets) and two ways, for 32 KB of capacity. Each stored tag is a full physical page number. Stores use write-back with write-allocate. Each set keeps a single LRU bit, and each line has a valid bit and a dirty bit. On a miss, a dirty victim is first sent out as eight 32-bit beats. The missing line is then fetched as eight beats, the arrays are read again, and the access completes as a hit.

Top module: `vipt_dcache`

## Requirements
- R1: After reset `reqReady` is 1, `respValid` is 0 and `memReq` is 0, and every line is invalid.
- R2: A load miss issues one read burst of 8 beats at byte address {physical page number, va[13:5], 5'b0}, where beat k carries word k of the line. The load then returns the word that va[4:2] selects.
- R3: An access that hits gives `respValid` in the cycle after the request is accepted. No memory traffic occurs, and the response lasts exactly one cycle.
- R4: A store hit replaces only the word that va[4:2] selects, and it marks the line dirty. A later load returns the stored value.
- R5: The set is va[13:5] and the tag is the translated page number. Two virtual addresses that translate to the same physical page hit the same line.
- R6: Two lines with different physical pages and the same index are resident together.
- R7: On a miss with both ways valid, the way used less recently is replaced, and the other line stays resident.
- R8: A dirty victim is written as 8 beats at {victim tag, index, 5'b0} before the fill begins. A clean victim causes no write beats.
- R9: While `xlatStall` is 1 during a lookup, no response and no memory request appear. The access completes once the stall is released.
- R10: A store miss fetches the line and then merges the store word into it. The other words keep their memory values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Access request present |
| reqReady | output | 1 | Cache can accept a request this cycle |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqVaddr | input | 32 | Virtual byte address (word aligned) |
| reqWdata | input | 32 | Store data |
| respValid | output | 1 | Access completes this cycle |
| respRdata | output | 32 | Load data, valid with respValid |
| xlatVpn | output | 18 | Virtual page number being translated |
| xlatPpn | input | 26 | Physical page number for xlatVpn |
| xlatStall | input | 1 | Translation not ready; hold the lookup |
| memReq | output | 1 | Burst in progress |
| memWrite | output | 1 | 1 = write-back burst, 0 = fill burst |
| memAddr | output | 40 | Line-aligned physical byte address |
| memWdata | output | 32 | Write-back beat data |
| memAck | input | 1 | Beat transferred this cycle |
| memRdata | input | 32 | Fill beat data, valid with memAck |

## Verification
The bench drives loads and stores against a behavioural memory and a translation table in which two virtual pages alias one physical page. It sweeps every word of one line, so a word-select or merge error cannot hide behind a neighbouring word. It also runs a series of misses and hits on one set that makes LRU order matter, and it checks whether a clean victim or a dirty victim causes write beats. A sweep of stores and loads over sets spread across the index range, including the last set, separates index-bit errors from tag errors. Translation stalls and gaps in memory acknowledgement show whether the control holds its state instead of running ahead.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_FILL,
    ST_REREAD
  } cstate_t;

  typedef struct packed {
    logic       capReq;
    logic       rdEn;
    logic       hitUpd;
    logic       missLatch;
    logic       wbPhase;
    logic       fillBeat;
    logic       fillCommit;
    logic [7:0] beat;
  } ctl_t;

endpackage

// File: rtl/vipt_datapath.sv
module vipt_datapath
  import vipt_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 40,
  parameter int PAGE_BITS  = 14,
  parameter int LINE_BYTES = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  ctl_t                           ctl,
  input  logic [VA_W-1:0]                reqVaddr,
  input  logic                           reqWrite,
  input  logic [31:0]                    reqWdata,
  input  logic [PA_W-PAGE_BITS-1:0]      xlatPpn,
  input  logic [31:0]                    memRdata,
  output logic                           hit,
  output logic                           victimDirty,
  output logic [31:0]                    respRdata,
  output logic [VA_W-PAGE_BITS-1:0]      xlatVpn,
  output logic [PA_W-1:0]                memAddr,
  output logic [31:0]                    memWdata
);
  localparam int WAYS   = 2;  // single LRU bit per set implies two ways
  localparam int WORD_W = 32;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = PAGE_BITS - OFF_W;
  localparam int SETS   = 1 << IDX_W;
  localparam int PPN_W  = PA_W - PAGE_BITS;
  localparam int VPN_W  = VA_W - PAGE_BITS;
  localparam int BEATS  = LINE_BYTES / 4;
  localparam int WSEL_W = $clog2(BEATS);
  localparam int LINE_W = LINE_BYTES * 8;

  // held request
  logic [IDX_W-1:0]  heldIdx;
  logic [WSEL_W-1:0] heldWsel;
  logic              heldWrite;
  logic [31:0]       heldWdata;
  logic [VPN_W-1:0]  heldVpn;

  logic unusedBits;
  assign unusedBits = ^{reqVaddr[1:0], ctl.beat[7:WSEL_W]};

  always_ff @(posedge clk) begin
    if (ctl.capReq) begin
      heldIdx   <= reqVaddr[PAGE_BITS-1:OFF_W];
      heldWsel  <= reqVaddr[OFF_W-1:2];
      heldWrite <= reqWrite;
      heldWdata <= reqWdata;
      heldVpn   <= reqVaddr[VA_W-1:PAGE_BITS];
    end
  end
  assign xlatVpn = heldVpn;

  logic [IDX_W-1:0] rdIdx;
  logic             rdAny;
  assign rdAny = ctl.capReq | ctl.rdEn;
  assign rdIdx = ctl.capReq ? reqVaddr[PAGE_BITS-1:OFF_W] : heldIdx;

  // per-way read results
  logic [PPN_W-1:0]  wayTag  [WAYS];
  logic [LINE_W-1:0] wayLine [WAYS];
  logic [WAYS-1:0]   wayValid, wayDirty, wayHit;

  logic              hitWay, victimWay, victimWayQ, rdLruQ;
  logic [PPN_W-1:0]  wbTagQ, fillPpnQ;
  logic [LINE_W-1:0] wbLineQ, fillBuf, fillLineNext, mergedLine;
  logic [WSEL_W-1:0] beatIdx;

  assign beatIdx = ctl.beat[WSEL_W-1:0];

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [PPN_W-1:0]  tagArr  [SETS];
      logic [LINE_W-1:0] dataArr [SETS];
      logic [SETS-1:0]   validVec, dirtyVec;
      logic [PPN_W-1:0]  rdTagQ;
      logic [LINE_W-1:0] rdLineQ;
      logic              rdValidQ, rdDirtyQ;
      logic              doFill, doStore;

      assign doFill  = ctl.fillCommit && (victimWayQ == 1'(w));
      assign doStore = ctl.hitUpd && heldWrite && (hitWay == 1'(w));

      always_ff @(posedge clk) begin
        if (rdAny) begin
          rdTagQ  <= tagArr[rdIdx];
          rdLineQ <= dataArr[rdIdx];
        end
        if (doFill) begin
          tagArr[heldIdx]  <= fillPpnQ;
          dataArr[heldIdx] <= fillLineNext;
        end else if (doStore) begin
          dataArr[heldIdx] <= mergedLine;
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          validVec <= '0;
          dirtyVec <= '0;
          rdValidQ <= 1'b0;
          rdDirtyQ <= 1'b0;
        end else begin
          if (rdAny) begin
            rdValidQ <= validVec[rdIdx];
            rdDirtyQ <= dirtyVec[rdIdx];
          end
          if (doFill) begin
            validVec[heldIdx] <= 1'b1;
            dirtyVec[heldIdx] <= 1'b0;
          end else if (doStore) begin
            dirtyVec[heldIdx] <= 1'b1;
          end
        end
      end

      assign wayTag[w]   = rdTagQ;
      assign wayLine[w]  = rdLineQ;
      assign wayValid[w] = rdValidQ;
      assign wayDirty[w] = rdDirtyQ;
      assign wayHit[w]   = rdValidQ && (rdTagQ == xlatPpn);
    end
  endgenerate

  // replacement state: lruVec bit names the way to evict next
  logic [SETS-1:0] lruVec;
  always_ff @(posedge clk) begin
    if (rst) begin
      lruVec <= '0;
      rdLruQ <= 1'b0;
    end else begin
      if (rdAny) rdLruQ <= lruVec[rdIdx];
      if (ctl.hitUpd) lruVec[heldIdx] <= ~hitWay;
    end
  end

  assign hit    = |wayHit;
  assign hitWay = wayHit[1];

  always_comb begin
    if (!wayValid[0])      victimWay = 1'b0;
    else if (!wayValid[1]) victimWay = 1'b1;
    else                   victimWay = rdLruQ;
  end
  assign victimDirty = wayValid[victimWay] && wayDirty[victimWay];

  always_comb begin
    mergedLine = wayLine[hitWay];
    mergedLine[32'(heldWsel) * WORD_W +: WORD_W] = heldWdata;
  end
  assign respRdata = wayLine[hitWay][32'(heldWsel) * WORD_W +: WORD_W];

  // miss bookkeeping and fill assembly
  always_ff @(posedge clk) begin
    if (ctl.missLatch) begin
      victimWayQ <= victimWay;
      wbTagQ     <= wayTag[victimWay];
      wbLineQ    <= wayLine[victimWay];
      fillPpnQ   <= xlatPpn;
    end
    if (ctl.fillBeat) fillBuf <= fillLineNext;
  end

  always_comb begin
    fillLineNext = fillBuf;
    fillLineNext[32'(beatIdx) * WORD_W +: WORD_W] = memRdata;
  end

  assign memWdata = wbLineQ[32'(beatIdx) * WORD_W +: WORD_W];
  assign memAddr  = ctl.wbPhase ? {wbTagQ, heldIdx, {OFF_W{1'b0}}}
                                : {fillPpnQ, heldIdx, {OFF_W{1'b0}}};
endmodule

// File: rtl/vipt_control.sv
module vipt_control
  import vipt_pkg::*;
#(
  parameter int LINE_BYTES = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic reqValid,
  output logic reqReady,
  output logic respValid,
  input  logic xlatStall,
  input  logic hit,
  input  logic victimDirty,
  output logic memReq,
  output logic memWrite,
  input  logic memAck,
  output ctl_t ctl
);
  localparam int BEATS  = LINE_BYTES / 4;
  localparam int WSEL_W = $clog2(BEATS);
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(BEATS - 1);

  cstate_t           st, stNext;
  logic [WSEL_W-1:0] beatQ, beatNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      beatQ <= '0;
    end else begin
      st    <= stNext;
      beatQ <= beatNext;
    end
  end

  always_comb begin
    ctl       = '0;
    ctl.beat  = 8'(beatQ);
    stNext    = st;
    beatNext  = beatQ;
    reqReady  = 1'b0;
    respValid = 1'b0;
    memReq    = 1'b0;
    memWrite  = 1'b0;
    case (st)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.capReq = 1'b1;
          stNext     = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (!xlatStall) begin
          if (hit) begin
            ctl.hitUpd = 1'b1;
            respValid  = 1'b1;
            stNext     = ST_IDLE;
          end else begin
            ctl.missLatch = 1'b1;
            beatNext      = '0;
            stNext        = victimDirty ? ST_WB : ST_FILL;
          end
        end
      end
      ST_WB: begin
        memReq      = 1'b1;
        memWrite    = 1'b1;
        ctl.wbPhase = 1'b1;
        if (memAck) begin
          if (beatQ == LAST_BEAT) begin
            beatNext = '0;
            stNext   = ST_FILL;
          end else begin
            beatNext = beatQ + 1'b1;
          end
        end
      end
      ST_FILL: begin
        memReq = 1'b1;
        if (memAck) begin
          ctl.fillBeat = 1'b1;
          if (beatQ == LAST_BEAT) begin
            ctl.fillCommit = 1'b1;
            beatNext       = '0;
            stNext         = ST_REREAD;
          end else begin
            beatNext = beatQ + 1'b1;
          end
        end
      end
      ST_REREAD: begin
        ctl.rdEn = 1'b1;
        stNext   = ST_LOOK;
      end
      default: stNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache
  import vipt_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 40,
  parameter int PAGE_BITS  = 14,
  parameter int LINE_BYTES = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reqValid,
  output logic                      reqReady,
  input  logic                      reqWrite,
  input  logic [VA_W-1:0]           reqVaddr,
  input  logic [31:0]               reqWdata,
  output logic                      respValid,
  output logic [31:0]               respRdata,
  output logic [VA_W-PAGE_BITS-1:0] xlatVpn,
  input  logic [PA_W-PAGE_BITS-1:0] xlatPpn,
  input  logic                      xlatStall,
  output logic                      memReq,
  output logic                      memWrite,
  output logic [PA_W-1:0]           memAddr,
  output logic [31:0]               memWdata,
  input  logic                      memAck,
  input  logic [31:0]               memRdata
);
  ctl_t ctl;
  logic hit, victimDirty;

  vipt_control #(.LINE_BYTES(LINE_BYTES)) u_ctl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .respValid(respValid), .xlatStall(xlatStall), .hit(hit),
    .victimDirty(victimDirty), .memReq(memReq), .memWrite(memWrite),
    .memAck(memAck), .ctl(ctl)
  );

  vipt_datapath #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .LINE_BYTES(LINE_BYTES)
  ) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .reqVaddr(reqVaddr), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .xlatPpn(xlatPpn), .memRdata(memRdata), .hit(hit),
    .victimDirty(victimDirty), .respRdata(respRdata), .xlatVpn(xlatVpn),
    .memAddr(memAddr), .memWdata(memWdata)
  );
endmodule

// File: rtl/vipt_dcache_chk.sv
module vipt_dcache_chk #(
  parameter int PA_W = 40
) (
  input logic            clk,
  input logic            rst,
  input logic            reqReady,
  input logic            respValid,
  input logic            xlatStall,
  input logic            memReq,
  input logic            memWrite,
  input logic [PA_W-1:0] memAddr
);
  a_r3_single_resp: assert property (@(posedge clk) disable iff (rst)
    respValid |=> !respValid);

  a_r3_no_mem_with_resp: assert property (@(posedge clk) disable iff (rst)
    respValid |-> !memReq);

  a_r1_resp_only_busy: assert property (@(posedge clk) disable iff (rst)
    respValid |-> !reqReady);

  a_r9_stall_no_resp: assert property (@(posedge clk) disable iff (rst)
    respValid |-> !xlatStall);

  a_r8_write_in_burst: assert property (@(posedge clk) disable iff (rst)
    memWrite |-> memReq);

  a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (memReq && $past(memReq) && (memWrite == $past(memWrite))) |-> $stable(memAddr));
endmodule

bind vipt_dcache vipt_dcache_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst(rst), .reqReady(reqReady), .respValid(respValid),
  .xlatStall(xlatStall), .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr)
);

// File: tb/vipt_dcache_tb.sv
module vipt_dcache_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqVaddr = '0, reqWdata = '0;
  logic        reqReady, respValid;
  logic [31:0] respRdata;
  logic [17:0] xlatVpn;
  logic [25:0] xlatPpn;
  logic        xlatStall = 1'b0;
  logic        memReq, memWrite, memAck = 1'b0;
  logic [39:0] memAddr;
  logic [31:0] memWdata, memRdata = '0;

  int compared = 0, mismatched = 0;
  int rdBeats = 0, wrBeats = 0, mb = 0, cyc = 0;
  logic [39:0] lastWbAddr = '0, lastFillAddr = '0;
  logic [31:0] phys [logic [39:0]];
  logic [31:0] refm [logic [39:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  vipt_dcache u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqVaddr(reqVaddr), .reqWdata(reqWdata),
    .respValid(respValid), .respRdata(respRdata), .xlatVpn(xlatVpn),
    .xlatPpn(xlatPpn), .xlatStall(xlatStall), .memReq(memReq),
    .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata)
  );

  // translation: vpn bits 17:16 ignored, so 0x00011 and 0x10011 alias
  function automatic logic [25:0] tlbMap(input logic [17:0] vpn);
    return {10'h12C, vpn[15:0]};
  endfunction
  assign xlatPpn = tlbMap(xlatVpn);

  function automatic logic [31:0] memInit(input logic [39:0] pa);
    return pa[33:2] ^ 32'h5EED_1234;
  endfunction
  function automatic logic [31:0] physRd(input logic [39:0] pa);
    return phys.exists(pa) ? phys[pa] : memInit(pa);
  endfunction
  function automatic logic [31:0] refRd(input logic [39:0] pa);
    return refm.exists(pa) ? refm[pa] : memInit(pa);
  endfunction
  function automatic logic [31:0] mkVa(input logic [17:0] vpn, input logic [8:0] idx,
                                      input logic [2:0] w);
    return {vpn, idx, w, 2'b00};
  endfunction
  function automatic logic [39:0] paOf(input logic [31:0] va);
    return {tlbMap(va[31:14]), va[13:0]};
  endfunction

  // memory model: acknowledges with a gap every fourth cycle
  always @(negedge clk) begin
    logic ackNow;
    logic [39:0] a;
    cyc++;
    if (memReq) begin
      ackNow = (cyc % 4) != 1;
      if (ackNow) begin
        a = memAddr + 40'(mb * 4);
        if (memWrite) begin
          if (mb == 0) lastWbAddr = memAddr;
          phys[a] = memWdata;
          wrBeats++;
        end else begin
          if (mb == 0) lastFillAddr = memAddr;
          memRdata = physRd(a);
          rdBeats++;
        end
        mb = (mb == 7) ? 0 : mb + 1;
      end
      memAck = ackNow;
    end else begin
      memAck = 1'b0;
      mb = 0;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [31:0] va, input logic [31:0] wd,
                        output logic [31:0] rd, output int lat);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqVaddr = va; reqWdata = wd;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!respValid && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
    rd = respRdata;
    if (wr) refm[paOf(va)] = wd;
  endtask

  task automatic loadChk(input string req, input logic [31:0] va, input bit expectHit);
    logic [31:0] rd;
    int lat;
    access(1'b0, va, 32'h0, rd, lat);
    check(req, rd, refRd(paOf(va)));
    if (expectHit) check(req, lat, 1);
    else check(req, (lat > 1), 1);
  endtask

  localparam logic [8:0]  IDX = 9'd3;
  localparam logic [17:0] VA_ = 18'h00011, VAAL = 18'h10011, VB = 18'h00022,
                          VC = 18'h00033, VD = 18'h00044, VE = 18'h00055;

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int lat, rb, wb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 reqReady", reqReady, 1);
    check("R1 respValid", respValid, 0);
    check("R1 memReq", memReq, 0);

    // R2 load miss, clean fill, R8 no write-back of an invalid victim
    rb = rdBeats; wb = wrBeats;
    loadChk("R2 miss data", mkVa(VA_, IDX, 3'd2), 1'b0);
    check("R2 fill beats", rdBeats - rb, 8);
    check("R8 no wb on clean", wrBeats - wb, 0);
    check("R2 fill addr", lastFillAddr, {tlbMap(VA_), IDX, 5'b0});

    // R3 hit latency, no traffic
    rb = rdBeats;
    loadChk("R3 hit", mkVa(VA_, IDX, 3'd5), 1'b1);
    check("R3 no traffic", rdBeats - rb, 0);

    // R4 store every word, read each back
    for (int w = 0; w < 8; w++) begin
      access(1'b1, mkVa(VA_, IDX, 3'(w)), 32'hA000_0000 + 32'(w * 17), rd, lat);
      check("R4 store hit latency", lat, 1);
    end
    for (int w = 0; w < 8; w++) loadChk("R4 readback", mkVa(VA_, IDX, 3'(w)), 1'b1);

    // R5 alias hits same line
    loadChk("R5 alias", mkVa(VAAL, IDX, 3'd4), 1'b1);
    access(1'b1, mkVa(VAAL, IDX, 3'd6), 32'h0BAD_F00D, rd, lat);
    loadChk("R5 alias store seen", mkVa(VA_, IDX, 3'd6), 1'b1);

    // R9 translation stall holds the lookup
    @(negedge clk);
    xlatStall = 1'b1;
    reqValid = 1'b1; reqWrite = 1'b0; reqVaddr = mkVa(VA_, IDX, 3'd1);
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check("R9 no resp in stall", respValid, 0);
      check("R9 no mem in stall", memReq, 0);
      @(negedge clk);
    end
    xlatStall = 1'b0;
    #1;
    check("R9 resp on release", respValid, 1);
    check("R9 data on release", respRdata, refRd(paOf(mkVa(VA_, IDX, 3'd1))));
    @(negedge clk);
    check("R3 one-cycle resp", respValid, 0);

    // R6 second way
    loadChk("R6 B miss", mkVa(VB, IDX, 3'd0), 1'b0);
    loadChk("R6 A still", mkVa(VA_, IDX, 3'd0), 1'b1);
    loadChk("R6 B still", mkVa(VB, IDX, 3'd7), 1'b1);
    // R7 make A recent, C replaces B
    loadChk("R7 touch A", mkVa(VA_, IDX, 3'd3), 1'b1);
    wb = wrBeats;
    loadChk("R7 C miss", mkVa(VC, IDX, 3'd1), 1'b0);
    check("R8 clean victim no wb", wrBeats - wb, 0);
    loadChk("R7 A kept", mkVa(VA_, IDX, 3'd2), 1'b1);
    loadChk("R7 B evicted", mkVa(VB, IDX, 3'd2), 1'b0);
    // R8 C miss now evicts dirty A
    wb = wrBeats;
    loadChk("R8 C refetch", mkVa(VC, IDX, 3'd5), 1'b0);
    check("R8 wb beats", wrBeats - wb, 8);
    check("R8 wb addr", lastWbAddr, {tlbMap(VA_), IDX, 5'b0});
    for (int w = 0; w < 8; w++) begin
      logic [39:0] pa;
      pa = paOf(mkVa(VA_, IDX, 3'(w)));
      check("R8 wb data", physRd(pa), refRd(pa));
    end
    loadChk("R8 A from memory", mkVa(VA_, IDX, 3'd6), 1'b0);

    // R10 store miss allocates and merges
    access(1'b1, mkVa(VD, 9'd7, 3'd1), 32'h1234_5678, rd, lat);
    check("R10 store miss latency", (lat > 1), 1);
    loadChk("R10 merged word", mkVa(VD, 9'd7, 3'd1), 1'b1);
    loadChk("R10 other word", mkVa(VD, 9'd7, 3'd0), 1'b1);

    // R5 index sweep across the set range, ending at set 511
    for (int i = 0; i < 32; i++) begin
      access(1'b1, mkVa(VE, 9'(i * 16 + 15), 3'(i)), 32'hC0DE_0000 + 32'(i), rd, lat);
      check("R10 sweep store miss", (lat > 1), 1);
    end
    for (int i = 0; i < 32; i++)
      loadChk("R5 sweep readback", mkVa(VE, 9'(i * 16 + 15), 3'(i)), 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule